// File: doc/BRIEF.md
# Tower-pair input receiver and jet-element lane multiplexer

This block takes two deserialised input words per bunch period, one from an electromagnetic channel and one from a hadronic channel of the same tower pair. It checks each word's parity and pulls out its 9-bit energy. It then adds the two energies into a 10-bit jet element, with 1 GeV per count. The jet element leaves the block on a 5-line bus that runs at twice the bunch rate, as two halves.

For each channel, the raw energy and two error flags (bad parity, bad link) are kept in registers for the readout path. When a channel's word is flagged, its energy counts as zero in the pre-sum.

The block runs on the double-rate clock. An input, `bunch_phase`, is high on the first fast cycle of each bunch period, and every bunch-rate register samples on that cycle. The jet element path carries no parity of its own.

Top module: `jet_elem_packer`

## Requirements
- R1: An input word is 10 bits. Bits 9:1 carry the energy, which the block puts out unchanged on the channel's readout data. Bit 0 is chosen so that the whole word has an odd number of ones.
- R2: A channel's parity flag is set when its captured word has an even number of ones.
- R3: A channel's link flag repeats the link-bad input that was sampled together with the word.
- R4: The readout data and both flags hold their values across the second fast cycle of a bunch period. They change only after a fast edge where `bunch_phase` is high.
- R5: The jet element is the 10-bit sum of the two 9-bit energies and covers 0 to 1022 without wrapping.
- R6: A channel with its parity or link flag set adds zero to the jet element. Its readout data still shows the raw energy.
- R7: For one fast cycle the lanes carry jet element bits 4:0. For the next fast cycle they carry bits 9:5.
- R8: Take a word pair sampled at a fast edge where `bunch_phase` is high. Its readout values and the low half of its jet element appear after the next such edge. The high half follows one fast cycle later.
- R9: While reset is held, all outputs are zero. The first bunch period after reset shows zero energy, zero lanes and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bunch_phase | input | 1 | High on the first fast cycle of each bunch period |
| em_word | input | 10 | Electromagnetic input word, bit 0 is parity |
| had_word | input | 10 | Hadronic input word, bit 0 is parity |
| em_link_bad | input | 1 | Link fault reported for the em word |
| had_link_bad | input | 1 | Link fault reported for the had word |
| lane_out | output | 5 | Jet element half, low half first |
| em_ro_data | output | 9 | Electromagnetic raw energy for readout |
| em_ro_perr | output | 1 | Electromagnetic parity error flag |
| em_ro_lerr | output | 1 | Electromagnetic link error flag |
| had_ro_data | output | 9 | Hadronic raw energy for readout |
| had_ro_perr | output | 1 | Hadronic parity error flag |
| had_ro_lerr | output | 1 | Hadronic link error flag |

## Verification
The bench drives two energies of 511 each. If the sum were truncated to 9 bits, the high lane half would read 15 instead of 31. It also drives words with only one channel in error and with both in error. A design that masked before the parity check, or masked the readout data, would then show a wrong total or a zeroed readout value. Random words with one parity bit flipped, combined with separate link faults, catch flags that are inverted or swapped between channels. A lane order that is reversed, or off by one fast cycle, shows up as a swapped pair of halves on every bunch.

// File: rtl/jelm_pkg.sv
package jelm_pkg;

   typedef struct packed {
      logic par_bad;
      logic link_bad;
   } chan_flags_t;

   localparam int CH_EM  = 0;
   localparam int CH_HAD = 1;
   localparam int N_CH   = 2;

endpackage

// File: rtl/link_word_check.sv
module link_word_check #(
   parameter int DATA_W     = 9,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic [DATA_W:0]      word,
   input  logic                 link_bad,
   output logic [DATA_W-1:0]    energy,
   output jelm_pkg::chan_flags_t flags
);
   logic ones_odd;

   assign ones_odd = ^word;
   assign energy   = word[DATA_W:1];

   generate
      if (ODD_PARITY) begin : g_odd
         assign flags.par_bad = ~ones_odd;
      end else begin : g_even
         assign flags.par_bad = ones_odd;
      end
   endgenerate

   assign flags.link_bad = link_bad;
endmodule

// File: rtl/elem_presum.sv
module elem_presum #(
   parameter int DATA_W      = 9,
   parameter bit ZERO_ON_ERR = 1'b1
) (
   input  logic [DATA_W-1:0]     em_energy,
   input  logic [DATA_W-1:0]     had_energy,
   input  jelm_pkg::chan_flags_t em_flags,
   input  jelm_pkg::chan_flags_t had_flags,
   output logic [DATA_W:0]       elem
);
   localparam int SUM_W = DATA_W + 1;

   logic [DATA_W-1:0] em_use;
   logic [DATA_W-1:0] had_use;

   generate
      if (ZERO_ON_ERR) begin : g_mask
         assign em_use  = (em_flags.par_bad  || em_flags.link_bad)  ? '0 : em_energy;
         assign had_use = (had_flags.par_bad || had_flags.link_bad) ? '0 : had_energy;
      end else begin : g_pass
         assign em_use  = em_energy;
         assign had_use = had_energy;
      end
   endgenerate

   assign elem = SUM_W'(em_use) + SUM_W'(had_use);
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
   parameter int LANES = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bunch_phase,
   input  logic [2*LANES-1:0] elem,
   output logic [LANES-1:0]   lanes
);
   logic [LANES-1:0] hi_hold_q;
   logic [LANES-1:0] lane_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q    <= '0;
         hi_hold_q <= '0;
      end else if (bunch_phase) begin
         lane_q    <= elem[LANES-1:0];
         hi_hold_q <= elem[2*LANES-1:LANES];
      end else begin
         lane_q    <= hi_hold_q;
      end
   end

   assign lanes = lane_q;
endmodule

// File: rtl/jet_elem_packer.sv
module jet_elem_packer #(
   parameter int DATA_W      = 9,
   parameter int LANES       = 5,
   parameter bit ODD_PARITY  = 1'b1,
   parameter bit ZERO_ON_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bunch_phase,
   input  logic [DATA_W:0]   em_word,
   input  logic [DATA_W:0]   had_word,
   input  logic              em_link_bad,
   input  logic              had_link_bad,
   output logic [LANES-1:0]  lane_out,
   output logic [DATA_W-1:0] em_ro_data,
   output logic              em_ro_perr,
   output logic              em_ro_lerr,
   output logic [DATA_W-1:0] had_ro_data,
   output logic              had_ro_perr,
   output logic              had_ro_lerr
);
   import jelm_pkg::*;

   localparam int WORD_W = DATA_W + 1;
   localparam int ELEM_W = DATA_W + 1;
   localparam logic [WORD_W-1:0] IDLE_WORD = ODD_PARITY ? WORD_W'(1) : '0;

   generate
      if (ELEM_W != 2 * LANES) begin : g_bad_lanes
         $error("jet element width must be twice the lane count");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("energy width too small");
      end
   endgenerate

   logic [N_CH-1:0][WORD_W-1:0] word_in;
   logic [N_CH-1:0]             link_in;
   logic [N_CH-1:0][WORD_W-1:0] word_q;
   logic [N_CH-1:0]             link_q;
   logic [N_CH-1:0][DATA_W-1:0] energy;
   chan_flags_t [N_CH-1:0]      flags;
   logic [N_CH-1:0][DATA_W-1:0] ro_data_q;
   chan_flags_t [N_CH-1:0]      ro_flags_q;
   logic [ELEM_W-1:0]           elem;

   assign word_in[CH_EM]  = em_word;
   assign word_in[CH_HAD] = had_word;
   assign link_in[CH_EM]  = em_link_bad;
   assign link_in[CH_HAD] = had_link_bad;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[ch] <= IDLE_WORD;
            link_q[ch] <= 1'b0;
         end else if (bunch_phase) begin
            word_q[ch] <= word_in[ch];
            link_q[ch] <= link_in[ch];
         end
      end

      link_word_check #(
         .DATA_W     (DATA_W),
         .ODD_PARITY (ODD_PARITY)
      ) u_check (
         .word     (word_q[ch]),
         .link_bad (link_q[ch]),
         .energy   (energy[ch]),
         .flags    (flags[ch])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ro_data_q[ch]  <= '0;
            ro_flags_q[ch] <= '0;
         end else if (bunch_phase) begin
            ro_data_q[ch]  <= energy[ch];
            ro_flags_q[ch] <= flags[ch];
         end
      end
   end

   elem_presum #(
      .DATA_W      (DATA_W),
      .ZERO_ON_ERR (ZERO_ON_ERR)
   ) u_sum (
      .em_energy  (energy[CH_EM]),
      .had_energy (energy[CH_HAD]),
      .em_flags   (flags[CH_EM]),
      .had_flags  (flags[CH_HAD]),
      .elem       (elem)
   );

   lane_serializer #(
      .LANES (LANES)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .bunch_phase (bunch_phase),
      .elem        (elem),
      .lanes       (lane_out)
   );

   assign em_ro_data  = ro_data_q[CH_EM];
   assign em_ro_perr  = ro_flags_q[CH_EM].par_bad;
   assign em_ro_lerr  = ro_flags_q[CH_EM].link_bad;
   assign had_ro_data = ro_data_q[CH_HAD];
   assign had_ro_perr = ro_flags_q[CH_HAD].par_bad;
   assign had_ro_lerr = ro_flags_q[CH_HAD].link_bad;
endmodule

// File: rtl/jelm_checker.sv
module jelm_checker #(
   parameter int DATA_W      = 9,
   parameter int LANES       = 5,
   parameter bit ODD_PARITY  = 1'b1,
   parameter bit ZERO_ON_ERR = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bunch_phase,
   input logic [DATA_W:0]   em_word,
   input logic [DATA_W:0]   had_word,
   input logic              em_link_bad,
   input logic              had_link_bad,
   input logic [LANES-1:0]  lane_out,
   input logic [DATA_W-1:0] em_ro_data,
   input logic              em_ro_perr,
   input logic              em_ro_lerr,
   input logic [DATA_W-1:0] had_ro_data,
   input logic              had_ro_perr,
   input logic              had_ro_lerr
);
   localparam int ELEM_W = DATA_W + 1;

   logic              em_bad;
   logic              had_bad;
   logic              em_word_bad;
   logic [ELEM_W-1:0] ro_total;
   logic              zmask;

   assign zmask       = ZERO_ON_ERR;
   assign em_bad      = em_ro_perr | em_ro_lerr;
   assign had_bad     = had_ro_perr | had_ro_lerr;
   assign em_word_bad = ODD_PARITY ? ~(^em_word) : (^em_word);
   assign ro_total    = ELEM_W'((zmask && em_bad)  ? '0 : em_ro_data)
                      + ELEM_W'((zmask && had_bad) ? '0 : had_ro_data);

   AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bunch_phase |=> ($stable(em_ro_data) && $stable(had_ro_data)
                        && $stable(em_ro_perr) && $stable(had_ro_lerr))); // R4

   AST_LANES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bunch_phase, 2) && !$past(bunch_phase))
      |-> ({lane_out, $past(lane_out)} == ro_total)); // R7

   AST_BOTH_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (zmask && em_bad && had_bad) |-> (lane_out == '0)); // R6

   AST_EM_PERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bunch_phase && em_word_bad) |-> ##3 em_ro_perr); // R2

   AST_HAD_LERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bunch_phase && had_link_bad) |-> ##3 had_ro_lerr); // R3
endmodule

bind jet_elem_packer jelm_checker #(
   .DATA_W      (DATA_W),
   .LANES       (LANES),
   .ODD_PARITY  (ODD_PARITY),
   .ZERO_ON_ERR (ZERO_ON_ERR)
) u_jelm_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bunch_phase  (bunch_phase),
   .em_word      (em_word),
   .had_word     (had_word),
   .em_link_bad  (em_link_bad),
   .had_link_bad (had_link_bad),
   .lane_out     (lane_out),
   .em_ro_data   (em_ro_data),
   .em_ro_perr   (em_ro_perr),
   .em_ro_lerr   (em_ro_lerr),
   .had_ro_data  (had_ro_data),
   .had_ro_perr  (had_ro_perr),
   .had_ro_lerr  (had_ro_lerr)
);

// File: tb/test_jet_elem_packer.sv
module test_jet_elem_packer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bunch_phase = 1'b0;
   logic [9:0] em_word = '0;
   logic [9:0] had_word = '0;
   logic       em_link_bad = 1'b0;
   logic       had_link_bad = 1'b0;
   logic [4:0] lane_out;
   logic [8:0] em_ro_data;
   logic       em_ro_perr;
   logic       em_ro_lerr;
   logic [8:0] had_ro_data;
   logic       had_ro_perr;
   logic       had_ro_lerr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [9:0] p_em = 10'h001;
   logic [9:0] p_had = 10'h001;
   logic       p_eml = 1'b0;
   logic       p_hadl = 1'b0;

   jet_elem_packer i_jet_elem_packer (
      .clk          (clk),
      .rst_n        (rst_n),
      .bunch_phase  (bunch_phase),
      .em_word      (em_word),
      .had_word     (had_word),
      .em_link_bad  (em_link_bad),
      .had_link_bad (had_link_bad),
      .lane_out     (lane_out),
      .em_ro_data   (em_ro_data),
      .em_ro_perr   (em_ro_perr),
      .em_ro_lerr   (em_ro_lerr),
      .had_ro_data  (had_ro_data),
      .had_ro_perr  (had_ro_perr),
      .had_ro_lerr  (had_ro_lerr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic perr_of(logic [9:0] w);
      return ~(^w);
   endfunction

   function automatic int elem_of(logic [9:0] e, logic [9:0] h, logic el, logic hl);
      int s = 0;
      if (!(perr_of(e) || el)) s += int'(e[9:1]);
      if (!(perr_of(h) || hl)) s += int'(h[9:1]);
      return s;
   endfunction

   function automatic logic [9:0] good_word(logic [8:0] d);
      return {d, ~(^d)};
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic bunch(logic [9:0] e, logic [9:0] h, logic el, logic hl);
      int s;
      @(negedge clk);
      bunch_phase = 1'b1;
      em_word = e; had_word = h; em_link_bad = el; had_link_bad = hl;
      @(posedge clk);
      @(negedge clk);
      s = elem_of(p_em, p_had, p_eml, p_hadl);
      chk("R1", "em_ro_data", int'(em_ro_data), int'(p_em[9:1]));
      chk("R1", "had_ro_data", int'(had_ro_data), int'(p_had[9:1]));
      chk("R2", "em_ro_perr", int'(em_ro_perr), int'(perr_of(p_em)));
      chk("R2", "had_ro_perr", int'(had_ro_perr), int'(perr_of(p_had)));
      chk("R3", "em_ro_lerr", int'(em_ro_lerr), int'(p_eml));
      chk("R3", "had_ro_lerr", int'(had_ro_lerr), int'(p_hadl));
      chk("R8", "lane low half", int'(lane_out), s & 31);
      bunch_phase = 1'b0;
      em_word = '0; had_word = '0; em_link_bad = 1'b1; had_link_bad = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk("R7", "lane high half", int'(lane_out), (s >> 5) & 31);
      chk("R4", "em_ro_data hold", int'(em_ro_data), int'(p_em[9:1]));
      chk("R4", "had_ro_perr hold", int'(had_ro_perr), int'(perr_of(p_had)));
      p_em = e; p_had = h; p_eml = el; p_hadl = hl;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R9", "reset lanes", int'(lane_out), 0);
      chk("R9", "reset em data", int'(em_ro_data), 0);
      chk("R9", "reset flags", int'({em_ro_perr, em_ro_lerr, had_ro_perr, had_ro_lerr}), 0);
      rst_n = 1'b1;
      // first bunch after reset: outputs show idle zero, no flags (R9)
      bunch(good_word(9'd511), good_word(9'd511), 1'b0, 1'b0);  // R5 max sum
      bunch(good_word(9'd1), good_word(9'd0), 1'b0, 1'b0);
      bunch(good_word(9'd300), good_word(9'd200) ^ 10'h001, 1'b0, 1'b0); // R6 had parity bad
      bunch(good_word(9'd77), good_word(9'd88), 1'b1, 1'b0);    // R6 em link bad
      bunch(good_word(9'd5) ^ 10'h200, good_word(9'd6), 1'b0, 1'b1); // R6 both bad
      bunch(good_word(9'd0), good_word(9'd0), 1'b0, 1'b0);
      bunch(good_word(9'd31), good_word(9'd1), 1'b0, 1'b0);     // R7 carry into high half
      for (int i = 0; i < 400; i++) begin
         logic [9:0] e;
         logic [9:0] h;
         e = good_word(9'($urandom));
         h = good_word(9'($urandom));
         if ($urandom_range(3) == 0) e ^= 10'(1 << $urandom_range(9));
         if ($urandom_range(3) == 0) h ^= 10'(1 << $urandom_range(9));
         bunch(e, h, $urandom_range(9) == 0, $urandom_range(9) == 0);
      end
      bunch(good_word(9'd0), good_word(9'd0), 1'b0, 1'b0);
      finish_run();
   end
endmodule